// File: doc/BRIEF.md
# Timestamp Conflict Arbiter for Transactional Execution

This block sits beside one core and settles coherence conflicts while that core runs a critical section speculatively, with its lock elided. It holds a logical-clock timestamp made of a commit counter joined to the core's own id. The timestamp is exposed for stamping every outgoing request, and it is compared against the timestamp carried by each incoming request. A smaller timestamp is older and wins. A younger requester that hits a block the transaction holds is deferred: it gets a marker, and it is queued as a waiter. An older requester is served at once. The transaction then drops every held block and is told to restart. Its timestamp stays the same, so a transaction that keeps losing grows relatively older until it wins.

While the core waits on a block whose upstream holder answered with a marker, an incoming request for that same block is passed upstream as a probe. The probe carries the original requester's timestamp, so priority travels along a chain of waiters and a cyclic wait is broken. Several events end a transaction. A commit advances the counter. A restart drains the waiters deferred so far, one per cycle, and so does any other exit. Too many held blocks, a full waiter queue, or an operation that cannot be undone each force a fallback to taking the lock for real.

Top module: `tca_arbiter`

## Requirements
- R1: `stamp_ts` equals {commit counter, CORE_ID}, with the id in the low ID_W bits. The counter is 0 after reset, so the reset value is CORE_ID.
- R2: One timestamp is older than another when it is numerically smaller. Only a strictly smaller requester timestamp beats the local one.
- R3: During a transaction, a request to a held block whose timestamp is larger than `stamp_ts` is not served. One cycle later `mark_valid` pulses with that requester's id and address, and the requester is queued as a waiter.
- R4: During a transaction, a request to a held block whose timestamp is smaller than `stamp_ts` is served one cycle later, together with a `restart` pulse. `in_txn` stays 1, `stamp_ts` is unchanged, and every held block is released, so a later request to that address is served.
- R5: A request that hits neither a held block nor the pending upstream wait is served one cycle later through `svc_valid`/`svc_id`/`svc_addr`. This holds both inside and outside a transaction.
- R6: After `up_marker_valid` during a transaction, a request to the marked address produces, one cycle later, a probe to the recorded holder carrying the requester's address and timestamp, plus a marker to the requester. `up_grant_valid` ends the wait, and after that the address is treated normally.
- R7: `txn_end` during a transaction commits: `in_txn` drops, the counter advances by one, held blocks are released, and queued waiters come out on the drain port in arrival order, one per cycle, from the second cycle after the commit.
- R8: A restart drains the waiters queued before it, in the same way as a commit.
- R9: `txn_irrevocable` during a transaction pulses `fallback`, drops `in_txn`, leaves `stamp_ts` unchanged, and drains the waiters.
- R10: The hold table keeps RET_DEPTH distinct addresses, and a repeated address takes no new slot. Holding one more distinct address pulses `fallback` and drops `in_txn`.
- R11: When WQ_DEPTH waiters are queued, a further request that would be deferred is served instead, with a `fallback` pulse, and the transaction ends.
- R12: `txn_start` while a transaction is active changes nothing. `retain_valid` and `up_marker_valid` outside a transaction are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Enter transactional mode |
| txn_end | input | 1 | Transaction reached its end; commit |
| txn_irrevocable | input | 1 | An operation that cannot be undone was met |
| retain_valid | input | 1 | The core now holds a block for the transaction |
| retain_addr | input | ADDR_W | Block address being held |
| up_marker_valid | input | 1 | Marker received from an upstream holder |
| up_marker_addr | input | ADDR_W | Block the core waits on |
| up_marker_holder | input | ID_W | Id of the upstream holder |
| up_grant_valid | input | 1 | The awaited block has arrived |
| req_valid | input | 1 | Incoming coherence request |
| req_addr | input | ADDR_W | Requested block |
| req_ts | input | TS_W | Requester timestamp |
| req_id | input | ID_W | Requester id |
| stamp_ts | output | TS_W | Local timestamp attached to outgoing requests |
| in_txn | output | 1 | Transaction active |
| svc_valid | output | 1 | Service the request now |
| svc_id | output | ID_W | Served requester |
| svc_addr | output | ADDR_W | Served block |
| mark_valid | output | 1 | Send a marker (data deferred) |
| mark_id | output | ID_W | Marker destination |
| mark_addr | output | ADDR_W | Marked block |
| probe_valid | output | 1 | Forward a probe upstream |
| probe_dst | output | ID_W | Upstream holder |
| probe_addr | output | ADDR_W | Probed block |
| probe_ts | output | TS_W | Original requester timestamp |
| restart | output | 1 | Transaction lost a conflict; re-execute |
| fallback | output | 1 | Leave speculation and acquire the lock |
| drain_valid | output | 1 | Service a released waiter |
| drain_id | output | ID_W | Waiter id |
| drain_addr | output | ADDR_W | Waiter block |

## Verification
The bench targets the ordering boundary first. Requester timestamps one above and one below the local value must split into deferral and yield. A design that compared the two the wrong way round, or with a non-strict compare, would defer an older requester and stall it behind a younger one. It also checks that a restart leaves the timestamp unchanged and releases the held blocks. A design that bumped the counter on restart could starve a transaction, and one that kept stale entries would keep deferring after it had given up ownership. The probe path is checked to carry the requester's timestamp rather than the local one, and to end when the grant arrives. The hold table and the waiter queue are each driven one past full: a wrong overflow test would either drop a waiter silently or stay speculative without tracking a block.

// File: rtl/tca_pkg.sv
package tca_pkg;

    localparam int TS_MAX_W = 32;

    typedef enum logic [2:0] {
        DEC_NONE,
        DEC_SERVE,
        DEC_DEFER,
        DEC_FORWARD,
        DEC_YIELD,
        DEC_SPILL
    } dec_e;

    typedef enum logic [1:0] {
        EXIT_NONE,
        EXIT_COMMIT,
        EXIT_RESTART,
        EXIT_FALLBACK
    } exit_e;

    // Earlier (smaller) timestamp carries higher priority.
    function automatic logic ts_older(input logic [TS_MAX_W-1:0] a,
                                      input logic [TS_MAX_W-1:0] b);
        return a < b;
    endfunction

endpackage

// File: rtl/tca_retain_set.sv
module tca_retain_set #(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              add_en,
    input  logic [ADDR_W-1:0] add_addr,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic              add_present,
    output logic              add_full
);
    logic [DEPTH-1:0]  vld;
    logic [ADDR_W-1:0] tag [DEPTH];
    logic [DEPTH-1:0]  m_look, m_add, sel;
    logic              found;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            assign m_look[i] = vld[i] && (tag[i] == look_addr);
            assign m_add[i]  = vld[i] && (tag[i] == add_addr);

            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    vld[i] <= 1'b0;
                end else if (add_en && !add_present && sel[i]) begin
                    vld[i] <= 1'b1;
                    tag[i] <= add_addr;
                end
            end
        end
    endgenerate

    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!vld[i] && !found) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assign look_hit    = |m_look;
    assign add_present = |m_add;
    assign add_full    = !found;

    assert_unique_tags_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(m_look));
endmodule

// File: rtl/tca_waiter_q.sv
module tca_waiter_q #(
    parameter int ID_W   = 3,
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 3,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ID_W-1:0]   push_id,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic [ID_W-1:0]   head_id,
    output logic [ADDR_W-1:0] head_addr,
    output logic [CW-1:0]     count,
    output logic              full
);
    logic [ID_W-1:0]   id_mem   [DEPTH];
    logic [ADDR_W-1:0] addr_mem [DEPTH];
    logic [PW-1:0]     wr_p, rd_p;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_p  <= '0;
            rd_p  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                id_mem[wr_p]   <= push_id;
                addr_mem[wr_p] <= push_addr;
                wr_p           <= bump(wr_p);
            end
            if (pop) rd_p <= bump(rd_p);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head_id   = id_mem[rd_p];
    assign head_addr = addr_mem[rd_p];
    assign full      = (count == CW'(DEPTH));

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        !(push && full));
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
        pop |-> count != '0);
endmodule

// File: rtl/tca_arbiter.sv
module tca_arbiter
    import tca_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int ID_W      = 3,
    parameter int ADDR_W    = 12,
    parameter int RET_DEPTH = 4,
    parameter int WQ_DEPTH  = 3,
    parameter int CORE_ID   = 5,
    localparam int TS_W     = CNT_W + ID_W,
    localparam int QCW      = $clog2(WQ_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_start,
    input  logic              txn_end,
    input  logic              txn_irrevocable,
    input  logic              retain_valid,
    input  logic [ADDR_W-1:0] retain_addr,
    input  logic              up_marker_valid,
    input  logic [ADDR_W-1:0] up_marker_addr,
    input  logic [ID_W-1:0]   up_marker_holder,
    input  logic              up_grant_valid,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TS_W-1:0]   req_ts,
    input  logic [ID_W-1:0]   req_id,
    output logic [TS_W-1:0]   stamp_ts,
    output logic              in_txn,
    output logic              svc_valid,
    output logic [ID_W-1:0]   svc_id,
    output logic [ADDR_W-1:0] svc_addr,
    output logic              mark_valid,
    output logic [ID_W-1:0]   mark_id,
    output logic [ADDR_W-1:0] mark_addr,
    output logic              probe_valid,
    output logic [ID_W-1:0]   probe_dst,
    output logic [ADDR_W-1:0] probe_addr,
    output logic [TS_W-1:0]   probe_ts,
    output logic              restart,
    output logic              fallback,
    output logic              drain_valid,
    output logic [ID_W-1:0]   drain_id,
    output logic [ADDR_W-1:0] drain_addr
);
    logic [CNT_W-1:0]  cnt;
    logic              active;
    logic              wait_v;
    logic [ADDR_W-1:0] wait_addr;
    logic [ID_W-1:0]   wait_holder;
    logic [QCW-1:0]    drain_left;

    logic              ret_hit, ret_present, ret_full, ret_add, ret_clr;
    logic              q_push, q_pop, q_full;
    logic [QCW-1:0]    q_count;
    logic [ID_W-1:0]   q_head_id;
    logic [ADDR_W-1:0] q_head_addr;

    dec_e              dec;
    exit_e             ex;
    logic              go_start;

    assign stamp_ts = {cnt, ID_W'(CORE_ID)};
    assign in_txn   = active;

    tca_retain_set #(.ADDR_W(ADDR_W), .DEPTH(RET_DEPTH)) u_ret (
        .clk(clk), .rst(rst), .clr(ret_clr),
        .add_en(ret_add), .add_addr(retain_addr),
        .look_addr(req_addr), .look_hit(ret_hit),
        .add_present(ret_present), .add_full(ret_full)
    );

    tca_waiter_q #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DEPTH(WQ_DEPTH)) u_wq (
        .clk(clk), .rst(rst),
        .push(q_push), .push_id(req_id), .push_addr(req_addr),
        .pop(q_pop), .head_id(q_head_id), .head_addr(q_head_addr),
        .count(q_count), .full(q_full)
    );

    // Decision for the incoming request, taken against pre-edge state.
    always_comb begin
        dec = DEC_NONE;
        if (req_valid) begin
            if (wait_v && req_addr == wait_addr) begin
                dec = DEC_FORWARD;
            end else if (active && ret_hit) begin
                if (ts_older(TS_MAX_W'(req_ts), TS_MAX_W'(stamp_ts)))
                    dec = DEC_YIELD;
                else if (q_full)
                    dec = DEC_SPILL;
                else
                    dec = DEC_DEFER;
            end else begin
                dec = DEC_SERVE;
            end
        end
    end

    // Exit of the transaction, by priority.
    always_comb begin
        ex       = EXIT_NONE;
        ret_add  = 1'b0;
        go_start = 1'b0;
        if (dec == DEC_YIELD)                      ex = EXIT_RESTART;
        else if (dec == DEC_SPILL)                 ex = EXIT_FALLBACK;
        else if (active && txn_end)                ex = EXIT_COMMIT;
        else if (active && txn_irrevocable)        ex = EXIT_FALLBACK;
        else if (active && retain_valid) begin
            if (!ret_present && ret_full)          ex = EXIT_FALLBACK;
            else                                   ret_add = 1'b1;
        end else if (!active && txn_start)         go_start = 1'b1;
    end

    assign ret_clr = (ex != EXIT_NONE);
    assign q_push  = (dec == DEC_DEFER);
    assign q_pop   = (drain_left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '0;
            active      <= 1'b0;
            wait_v      <= 1'b0;
            wait_addr   <= '0;
            wait_holder <= '0;
            drain_left  <= '0;
            svc_valid   <= 1'b0;
            svc_id      <= '0;
            svc_addr    <= '0;
            mark_valid  <= 1'b0;
            mark_id     <= '0;
            mark_addr   <= '0;
            probe_valid <= 1'b0;
            probe_dst   <= '0;
            probe_addr  <= '0;
            probe_ts    <= '0;
            restart     <= 1'b0;
            fallback    <= 1'b0;
            drain_valid <= 1'b0;
            drain_id    <= '0;
            drain_addr  <= '0;
        end else begin
            svc_valid   <= dec inside {DEC_SERVE, DEC_YIELD, DEC_SPILL};
            mark_valid  <= dec inside {DEC_DEFER, DEC_FORWARD};
            probe_valid <= (dec == DEC_FORWARD);
            restart     <= (ex == EXIT_RESTART);
            fallback    <= (ex == EXIT_FALLBACK);
            drain_valid <= q_pop;
            if (req_valid) begin
                svc_id     <= req_id;
                svc_addr   <= req_addr;
                mark_id    <= req_id;
                mark_addr  <= req_addr;
                probe_addr <= req_addr;
                probe_ts   <= req_ts;
                probe_dst  <= wait_holder;
            end
            if (q_pop) begin
                drain_id   <= q_head_id;
                drain_addr <= q_head_addr;
            end

            if (ex == EXIT_COMMIT) cnt <= cnt + 1'b1;
            if (ex == EXIT_COMMIT || ex == EXIT_FALLBACK) active <= 1'b0;
            else if (go_start)                            active <= 1'b1;

            if (ex != EXIT_NONE) begin
                wait_v <= 1'b0;
            end else if (up_grant_valid) begin
                wait_v <= 1'b0;
            end else if (up_marker_valid && active) begin
                wait_v      <= 1'b1;
                wait_addr   <= up_marker_addr;
                wait_holder <= up_marker_holder;
            end

            if (ex != EXIT_NONE)
                drain_left <= q_count + QCW'(q_push) - QCW'(q_pop);
            else if (q_pop)
                drain_left <= drain_left - 1'b1;
        end
    end

    assert_marker_not_served_R3: assert property (@(posedge clk) disable iff (rst)
        !(svc_valid && mark_valid));
    assert_probe_marked_R6: assert property (@(posedge clk) disable iff (rst)
        probe_valid |-> mark_valid);
    assert_restart_serves_R4: assert property (@(posedge clk) disable iff (rst)
        restart |-> (svc_valid && in_txn));
    assert_restart_keeps_ts_R4: assert property (@(posedge clk) disable iff (rst)
        restart |-> $stable(stamp_ts));
    assert_fallback_exits_R9: assert property (@(posedge clk) disable iff (rst)
        fallback |-> (!in_txn && $stable(stamp_ts)));
    assert_commit_advances_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(in_txn) && !fallback) |-> !$stable(stamp_ts));
    assert_single_exit_R12: assert property (@(posedge clk) disable iff (rst)
        !(restart && fallback));
endmodule

// File: tb/tca_arbiter_tb.sv
module tca_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 6, ID_W = 3, ADDR_W = 12, RET_DEPTH = 4, WQ_DEPTH = 3;
    localparam int CORE_ID = 5;
    localparam int TS_W = CNT_W + ID_W;

    logic clk = 1'b0, rst = 1'b1;
    logic txn_start = 0, txn_end = 0, txn_irrevocable = 0;
    logic retain_valid = 0; logic [ADDR_W-1:0] retain_addr = '0;
    logic up_marker_valid = 0; logic [ADDR_W-1:0] up_marker_addr = '0;
    logic [ID_W-1:0] up_marker_holder = '0; logic up_grant_valid = 0;
    logic req_valid = 0; logic [ADDR_W-1:0] req_addr = '0;
    logic [TS_W-1:0] req_ts = '0; logic [ID_W-1:0] req_id = '0;
    logic [TS_W-1:0] stamp_ts, probe_ts;
    logic in_txn, svc_valid, mark_valid, probe_valid, restart, fallback, drain_valid;
    logic [ID_W-1:0] svc_id, mark_id, probe_dst, drain_id;
    logic [ADDR_W-1:0] svc_addr, mark_addr, probe_addr, drain_addr;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    tca_arbiter #(.CNT_W(CNT_W), .ID_W(ID_W), .ADDR_W(ADDR_W), .RET_DEPTH(RET_DEPTH),
                  .WQ_DEPTH(WQ_DEPTH), .CORE_ID(CORE_ID)) u_dut (
        .clk(clk), .rst(rst), .txn_start(txn_start), .txn_end(txn_end),
        .txn_irrevocable(txn_irrevocable), .retain_valid(retain_valid),
        .retain_addr(retain_addr), .up_marker_valid(up_marker_valid),
        .up_marker_addr(up_marker_addr), .up_marker_holder(up_marker_holder),
        .up_grant_valid(up_grant_valid), .req_valid(req_valid), .req_addr(req_addr),
        .req_ts(req_ts), .req_id(req_id), .stamp_ts(stamp_ts), .in_txn(in_txn),
        .svc_valid(svc_valid), .svc_id(svc_id), .svc_addr(svc_addr),
        .mark_valid(mark_valid), .mark_id(mark_id), .mark_addr(mark_addr),
        .probe_valid(probe_valid), .probe_dst(probe_dst), .probe_addr(probe_addr),
        .probe_ts(probe_ts), .restart(restart), .fallback(fallback),
        .drain_valid(drain_valid), .drain_id(drain_id), .drain_addr(drain_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference state
    int m_cnt = 0; bit m_act = 0, m_wv = 0; int m_wa = 0, m_wh = 0, m_dl = 0;
    int ret_q[$]; int wq_id[$]; int wq_ad[$];
    bit e_svc, e_mark, e_probe, e_rst, e_fb, e_drn;
    int e_sid, e_sad, e_mid, e_mad, e_pdst, e_pad, e_pts, e_did, e_dad;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit in_ret(input int a);
        foreach (ret_q[i]) if (ret_q[i] == a) return 1;
        return 0;
    endfunction

    task automatic model_step();
        bit a0 = m_act; bit clr = 0; bit exited = 0;
        int loc = m_cnt * (1 << ID_W) + CORE_ID;
        e_svc = 0; e_mark = 0; e_probe = 0; e_rst = 0; e_fb = 0; e_drn = 0;
        if (m_dl > 0) begin
            e_drn = 1; e_did = wq_id.pop_front(); e_dad = wq_ad.pop_front(); m_dl--;
        end
        if (req_valid) begin
            if (m_wv && req_addr == m_wa) begin
                e_mark = 1; e_mid = req_id; e_mad = req_addr;
                e_probe = 1; e_pdst = m_wh; e_pad = req_addr; e_pts = req_ts;
            end else if (a0 && in_ret(req_addr)) begin
                if (req_ts < loc) begin
                    e_svc = 1; e_sid = req_id; e_sad = req_addr; e_rst = 1; clr = 1; exited = 1;
                end else if (wq_id.size() + (e_drn ? 1 : 0) == WQ_DEPTH) begin
                    e_svc = 1; e_sid = req_id; e_sad = req_addr; e_fb = 1; m_act = 0;
                    clr = 1; exited = 1;
                end else begin
                    e_mark = 1; e_mid = req_id; e_mad = req_addr;
                    wq_id.push_back(req_id); wq_ad.push_back(req_addr);
                end
            end else begin
                e_svc = 1; e_sid = req_id; e_sad = req_addr;
            end
        end
        if (!exited) begin
            if (a0 && txn_end) begin
                m_cnt = (m_cnt + 1) % (1 << CNT_W); m_act = 0; clr = 1;
            end else if (a0 && txn_irrevocable) begin
                e_fb = 1; m_act = 0; clr = 1;
            end else if (a0 && retain_valid) begin
                if (!in_ret(retain_addr)) begin
                    if (ret_q.size() == RET_DEPTH) begin e_fb = 1; m_act = 0; clr = 1; end
                    else ret_q.push_back(retain_addr);
                end
            end else if (!a0 && txn_start) m_act = 1;
        end
        if (clr) begin m_wv = 0; ret_q.delete(); m_dl = wq_id.size(); end
        else if (up_grant_valid) m_wv = 0;
        else if (up_marker_valid && a0) begin
            m_wv = 1; m_wa = up_marker_addr; m_wh = up_marker_holder;
        end
    endtask

    task automatic compare();
        int loc = m_cnt * (1 << ID_W) + CORE_ID;
        chk(stamp_ts == loc, "R1 stamp_ts", stamp_ts, loc);
        chk(in_txn == m_act, "R12 in_txn", in_txn, m_act);
        chk(svc_valid == e_svc && (!e_svc || (svc_id == e_sid && svc_addr == e_sad)),
            "R5 service", {svc_valid, svc_id}, {e_svc, 3'(e_sid)});
        chk(mark_valid == e_mark && (!e_mark || (mark_id == e_mid && mark_addr == e_mad)),
            "R3 marker", {mark_valid, mark_id}, {e_mark, 3'(e_mid)});
        chk(probe_valid == e_probe && (!e_probe || (probe_dst == e_pdst &&
            probe_addr == e_pad && probe_ts == e_pts)), "R6 probe", probe_ts, e_pts);
        chk(restart == e_rst, "R4 restart", restart, e_rst);
        chk(fallback == e_fb, "R9 fallback", fallback, e_fb);
        chk(drain_valid == e_drn && (!e_drn || (drain_id == e_did && drain_addr == e_dad)),
            "R7 drain", {drain_valid, drain_id}, {e_drn, 3'(e_did)});
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk); @(negedge clk);
        compare();
        txn_start = 0; txn_end = 0; txn_irrevocable = 0; retain_valid = 0;
        up_marker_valid = 0; up_grant_valid = 0; req_valid = 0;
    endtask

    task automatic req(input int a, input int ts, input int id);
        req_valid = 1; req_addr = ADDR_W'(a); req_ts = TS_W'(ts); req_id = ID_W'(id); cyc();
    endtask
    task automatic hold(input int a); retain_valid = 1; retain_addr = ADDR_W'(a); cyc(); endtask
    task automatic start(); txn_start = 1; cyc(); endtask
    task automatic idle(); cyc(); endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        chk(stamp_ts == CORE_ID, "R1 reset ts", stamp_ts, CORE_ID);
        chk(in_txn == 0 && svc_valid == 0 && drain_valid == 0, "R1 reset idle", in_txn, 0);
        // R5 idle service
        req('h30, 7, 1);
        chk(svc_valid && svc_id == 1, "R5 idle serve", svc_id, 1);
        // R3 deferral of younger requesters
        start(); hold('h10); hold('h20);
        req('h10, 'h40, 1);
        chk(mark_valid && !svc_valid && mark_id == 1, "R3 defer", svc_valid, 0);
        req('h30, 'h40, 2);
        chk(svc_valid && svc_id == 2, "R5 nonconflict in txn", svc_valid, 1);
        req('h20, 'h41, 2);
        // R7 commit and ordered drain
        txn_end = 1; cyc();
        chk(!in_txn && stamp_ts == 13, "R7 commit ts", stamp_ts, 13);
        idle(); chk(drain_valid && drain_id == 1 && drain_addr == 'h10, "R7 drain first", drain_id, 1);
        idle(); chk(drain_valid && drain_id == 2 && drain_addr == 'h20, "R7 drain second", drain_id, 2);
        idle(); chk(!drain_valid, "R7 drain empty", drain_valid, 0);
        // R2 boundary: 14 younger, 12 older than 13
        start(); hold('h10);
        req('h10, 14, 6);
        chk(mark_valid && !restart, "R2 ts 14 younger", mark_valid, 1);
        req('h10, 12, 3);
        chk(svc_valid && svc_id == 3 && restart && in_txn && stamp_ts == 13,
            "R4 yield", restart, 1);
        idle(); chk(drain_valid && drain_id == 6, "R8 restart drains", drain_id, 6);
        req('h10, 'h40, 1);
        chk(svc_valid && !mark_valid, "R4 released", svc_valid, 1);
        // R6 probe forwarding
        up_marker_valid = 1; up_marker_addr = 'h50; up_marker_holder = 2; cyc();
        req('h50, 'h21, 4);
        chk(probe_valid && probe_dst == 2 && probe_ts == 'h21 && probe_addr == 'h50 &&
            mark_valid && mark_id == 4, "R6 probe", probe_ts, 'h21);
        up_grant_valid = 1; cyc();
        req('h50, 'h21, 4);
        chk(svc_valid && !probe_valid, "R6 grant ends wait", svc_valid, 1);
        // R9 irrevocable
        txn_irrevocable = 1; cyc();
        chk(fallback && !in_txn && stamp_ts == 13, "R9 fallback", fallback, 1);
        // R10 hold table overflow
        start(); hold(1); hold(2); hold(2); hold(3); hold(4);
        chk(!fallback && in_txn, "R10 dup no slot", fallback, 0);
        hold(5);
        chk(fallback && !in_txn, "R10 overflow", fallback, 1);
        // R11 waiter queue full
        start(); hold('h10);
        req('h10, 'h100, 1); req('h10, 'h101, 2); req('h10, 'h102, 3);
        req('h10, 'h103, 4);
        chk(svc_valid && svc_id == 4 && fallback && !in_txn, "R11 spill", fallback, 1);
        idle(); chk(drain_valid && drain_id == 1, "R11 drain after spill", drain_id, 1);
        idle(); idle(); idle();
        // R12 ignored inputs
        hold('h10);
        up_marker_valid = 1; up_marker_addr = 'h60; up_marker_holder = 1; cyc();
        req('h10, 'h100, 2);
        chk(svc_valid && !mark_valid, "R12 idle hold ignored", svc_valid, 1);
        req('h60, 'h100, 2);
        chk(svc_valid && !probe_valid, "R12 idle marker ignored", probe_valid, 0);
        start(); start();
        chk(in_txn && stamp_ts == 13, "R12 restart of start ignored", stamp_ts, 13);
        txn_end = 1; cyc();
        chk(stamp_ts == 21, "R7 second commit", stamp_ts, 21);
        idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule